// File: doc/BRIEF.md
# SCSI Initiator Bus Phase and Status Monitor

This block sits on the initiator side of a parallel SCSI port. It samples the bus control lines, the eight data lines and the data parity line. It compares the live information-transfer phase with a phase that software has programmed, and it holds the sticky error and interrupt flags that a driver uses to find out why the port needs attention. Arbitration, the REQ/ACK handshake engine and the DMA datapath are separate blocks. Only their end-of-process and request indications come into this monitor.

Software reaches the block through a small byte-wide register port. It programs a mode byte that enables parity checking, the parity interrupt, the end-of-process interrupt and busy monitoring. It also writes the expected phase code. It reads back two status bytes: the synchronised live bus lines and a latched status byte. A read at a dedicated clear address returns the latched byte and drops the error and interrupt flags. Both status bytes and the interrupt line also come out as ports.

Top module: `scsi_phase_monitor`

## Requirements
- R1: After synchronous reset the mode byte and the expected phase are zero, meaning data-out. The parity error, busy error and interrupt flags are clear and `irq` is low. With an idle bus the latched byte settles to 0x08.
- R2: `live_stat` holds, from bit 7 down to bit 0: RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP. Each bus line reaches it three clock edges after it changes: two synchroniser flops and one output register.
- R3: Phase codes are {MSG,C/D,I/O}: data-out 000, data-in 001, command 010, status 011, message-out 110, message-in 111. Latched bit 3 (phase match) is 1 exactly when the synchronised MSG, C/D and I/O lines equal the programmed expected phase.
- R4: `latch_stat` holds, from bit 7 down to bit 0: end-of-DMA (registered `dma_eop`), DMA request (registered `dma_req`), parity error, interrupt request, phase match, busy error, ATN, ACK.
- R5: A read at address 4 returns the latched byte. At the next edge it clears the parity error, interrupt and busy error flags together. If a set event for a flag arrives in the same cycle as the clear, the set wins.
- R6: On each rising edge of the synchronised REQ while I/O is high, the data lines and DBP must carry odd parity, meaning an odd number of ones over all nine bits. A violation sets the parity error flag only when mode bit 0 (parity check) is 1. No check is made while I/O is low.
- R7: A recorded parity error sets the interrupt flag only when mode bit 1 (parity interrupt enable) is also 1.
- R8: With mode bit 3 (busy monitor) set, a falling edge of the synchronised BSY sets both the busy error and interrupt flags. With the bit clear, a BSY loss has no effect.
- R9: A rising edge of `dma_eop` sets the interrupt flag only when mode bit 2 (end-of-process interrupt enable) is 1.
- R10: The register map has address 0 for the live byte, 1 for the latched byte, 2 for the mode (bits 3:0, read/write) and 3 for the expected phase (bits 2:0, read/write). Any other address reads zero. Read data appears on `reg_rdata` one edge after the read strobe.
- R11: `irq` follows the interrupt flag and is driven from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | SCSI RST line, active high |
| bus_bsy | input | 1 | SCSI BSY line |
| bus_sel | input | 1 | SCSI SEL line |
| bus_req | input | 1 | SCSI REQ line |
| bus_ack | input | 1 | SCSI ACK line |
| bus_atn | input | 1 | SCSI ATN line |
| bus_msg | input | 1 | SCSI MSG line |
| bus_cd | input | 1 | SCSI C/D line |
| bus_io | input | 1 | SCSI I/O line |
| bus_db | input | DW | SCSI data lines |
| bus_dbp | input | 1 | SCSI data parity line |
| dma_req | input | 1 | DMA request indication from the DMA engine |
| dma_eop | input | 1 | End-of-process indication from the DMA engine |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| live_stat | output | 8 | Synchronised live bus status byte |
| latch_stat | output | 8 | Latched bus-and-status byte |
| irq | output | 1 | Interrupt request |

## Verification
A parity-check or edge-detect fault shows up in bit 5 or bit 4 of the latched byte, and on `irq`, at the third edge after the REQ or BSY transition that caused it. A wrong synchroniser depth or a wrong bit order shows up in `live_stat` at that same edge. Phase-compare faults flip latched bit 3 on the same schedule. A failing clear leaves flags set at the edge after the clear read. A set-versus-clear priority fault can only be seen when the two events meet in one cycle, so the bench times an end-of-process edge onto a clear read.

// File: rtl/scsi_mon_pkg.sv
`timescale 1ns/1ps
package scsi_mon_pkg;
  localparam int REG_AW = 3;
  localparam int PH_W   = 3;
  localparam logic [REG_AW-1:0] A_LIVE  = 3'd0;
  localparam logic [REG_AW-1:0] A_LATCH = 3'd1;
  localparam logic [REG_AW-1:0] A_MODE  = 3'd2;
  localparam logic [REG_AW-1:0] A_PHASE = 3'd3;
  localparam logic [REG_AW-1:0] A_CLEAR = 3'd4;

  typedef struct packed {
    logic mon_bsy;  // bit 3
    logic eop_ie;   // bit 2
    logic par_ie;   // bit 1
    logic par_chk;  // bit 0
  } mode_t;
endpackage

// File: rtl/scsi_mon_sync.sv
`timescale 1ns/1ps
module scsi_mon_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end
endmodule

// File: rtl/scsi_mon_parity.sv
`timescale 1ns/1ps
module scsi_mon_parity #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          io,
  input  logic [DW-1:0] db,
  input  logic          dbp,
  output logic          bad
);
  logic req_prev_q;

  always_ff @(posedge clk) begin
    if (rst) req_prev_q <= 1'b0;
    else     req_prev_q <= req;
  end

  // odd parity over data plus parity line is the good case
  assign bad = req & ~req_prev_q & io & ~(^{db, dbp});

  AST_PAR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    bad |=> !bad); // R6
endmodule

// File: rtl/scsi_mon_flags.sv
`timescale 1ns/1ps
module scsi_mon_flags
  import scsi_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  par_bad,
  input  logic  bsy_lost,
  input  logic  eop_rise,
  input  logic  clr,
  output logic  perr_q,
  output logic  berr_q,
  output logic  intr_q
);
  logic par_set, berr_set, int_set;

  assign par_set  = par_bad & mode.par_chk;
  assign berr_set = bsy_lost & mode.mon_bsy;
  assign int_set  = (par_set & mode.par_ie) | berr_set | (eop_rise & mode.eop_ie);

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_q <= 1'b0;
      berr_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (par_set)       perr_q <= 1'b1;
      else if (clr)      perr_q <= 1'b0;
      if (berr_set)      berr_q <= 1'b1;
      else if (clr)      berr_q <= 1'b0;
      if (int_set)       intr_q <= 1'b1;
      else if (clr)      intr_q <= 1'b0;
    end
  end

  AST_CLEAR_DROPS_ALL: assert property (@(posedge clk) disable iff (rst)
    (clr && !par_bad && !bsy_lost && !eop_rise) |=> (!perr_q && !berr_q && !intr_q)); // R5
  AST_PERR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (rst)
    (!mode.par_chk && !perr_q) |=> !perr_q); // R6
  AST_BERR_NEEDS_MON: assert property (@(posedge clk) disable iff (rst)
    (!mode.mon_bsy && !berr_q) |=> !berr_q); // R8
  AST_INTR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!intr_q && !(par_bad && mode.par_chk && mode.par_ie)
      && !(bsy_lost && mode.mon_bsy) && !(eop_rise && mode.eop_ie)) |=> !intr_q); // R7
endmodule

// File: rtl/scsi_phase_monitor.sv
`timescale 1ns/1ps
module scsi_phase_monitor
  import scsi_mon_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_rst,
  input  logic          bus_bsy,
  input  logic          bus_sel,
  input  logic          bus_req,
  input  logic          bus_ack,
  input  logic          bus_atn,
  input  logic          bus_msg,
  input  logic          bus_cd,
  input  logic          bus_io,
  input  logic [DW-1:0] bus_db,
  input  logic          bus_dbp,
  input  logic          dma_req,
  input  logic          dma_eop,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic [7:0]    live_stat,
  output logic [7:0]    latch_stat,
  output logic          irq
);
  localparam int NCTL = 10;
  localparam int SW   = NCTL + DW;

  logic [SW-1:0] s_all;
  logic s_rst, s_bsy, s_sel, s_req, s_ack, s_atn, s_msg, s_cd, s_io, s_dbp;
  logic [DW-1:0] s_db;

  scsi_mon_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_rst, bus_bsy, bus_sel, bus_req, bus_ack, bus_atn,
           bus_msg, bus_cd, bus_io, bus_dbp, bus_db}),
    .q   (s_all)
  );
  assign {s_rst, s_bsy, s_sel, s_req, s_ack, s_atn,
          s_msg, s_cd, s_io, s_dbp, s_db} = s_all;

  mode_t           mode_q;
  logic [PH_W-1:0] exp_ph_q;
  logic            pm_q, bsy_prev_q, eop_q, eop_prev_q, dreq_q;
  logic            par_bad, bsy_lost, eop_rise, clr;
  logic            perr_q, berr_q, intr_q;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata[7:4];

  scsi_mon_parity #(.DW(DW)) u_par (
    .clk (clk), .rst (rst), .req (s_req), .io (s_io),
    .db  (s_db), .dbp (s_dbp), .bad (par_bad)
  );

  assign bsy_lost = bsy_prev_q & ~s_bsy;
  assign eop_rise = eop_q & ~eop_prev_q;
  assign clr      = reg_rd && (reg_addr == A_CLEAR);

  scsi_mon_flags u_flags (
    .clk (clk), .rst (rst), .mode (mode_q),
    .par_bad (par_bad), .bsy_lost (bsy_lost), .eop_rise (eop_rise),
    .clr (clr), .perr_q (perr_q), .berr_q (berr_q), .intr_q (intr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      exp_ph_q   <= '0;
      pm_q       <= 1'b0;
      bsy_prev_q <= 1'b0;
      eop_q      <= 1'b0;
      eop_prev_q <= 1'b0;
      dreq_q     <= 1'b0;
      live_stat  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_MODE)  mode_q   <= mode_t'(reg_wdata[3:0]);
      if (reg_wr && reg_addr == A_PHASE) exp_ph_q <= reg_wdata[PH_W-1:0];
      pm_q       <= ({s_msg, s_cd, s_io} == exp_ph_q);
      bsy_prev_q <= s_bsy;
      eop_q      <= dma_eop;
      eop_prev_q <= eop_q;
      dreq_q     <= dma_req;
      live_stat  <= {s_rst, s_bsy, s_req, s_msg, s_cd, s_io, s_sel, s_dbp};
    end
  end

  assign latch_stat = {eop_q, dreq_q, perr_q, intr_q, pm_q, berr_q, s_atn, s_ack};
  assign irq        = intr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_LIVE:           reg_rdata <= live_stat;
        A_LATCH, A_CLEAR: reg_rdata <= latch_stat;
        A_MODE:           reg_rdata <= {4'b0, mode_q};
        A_PHASE:          reg_rdata <= {5'b0, exp_ph_q};
        default:          reg_rdata <= '0;
      endcase
    end
  end

  AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pm_q == ({$past(s_msg), $past(s_cd), $past(s_io)} == $past(exp_ph_q)))); // R3
  AST_BUSY_LOSS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (bsy_lost && mode_q.mon_bsy) |=> (berr_q && irq)); // R8
  AST_EOP_IRQ: assert property (@(posedge clk) disable iff (rst)
    (eop_rise && mode_q.eop_ie) |=> irq); // R9
endmodule

// File: tb/test_scsi_phase_monitor.sv
`timescale 1ns/1ps
module test_scsi_phase_monitor;
  logic clk = 0;
  logic rst;
  logic b_rst, b_bsy, b_sel, b_req, b_ack, b_atn, b_msg, b_cd, b_io, b_dbp;
  logic [7:0] b_db;
  logic d_req, d_eop;
  logic [2:0] ra;
  logic rw, rr;
  logic [7:0] wd, rd, live, lat;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scsi_phase_monitor i_scsi_phase_monitor (
    .clk(clk), .rst(rst), .bus_rst(b_rst), .bus_bsy(b_bsy), .bus_sel(b_sel),
    .bus_req(b_req), .bus_ack(b_ack), .bus_atn(b_atn), .bus_msg(b_msg),
    .bus_cd(b_cd), .bus_io(b_io), .bus_db(b_db), .bus_dbp(b_dbp),
    .dma_req(d_req), .dma_eop(d_eop), .reg_addr(ra), .reg_wr(rw), .reg_rd(rr),
    .reg_wdata(wd), .reg_rdata(rd), .live_stat(live), .latch_stat(lat), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    ra = a; wd = d; rw = 1;
    @(posedge clk); @(negedge clk);
    rw = 0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    ra = a; rr = 1;
    @(posedge clk); @(negedge clk);
    rr = 0; d = rd;
  endtask

  function automatic logic [7:0] exp_live();
    return {b_rst, b_bsy, b_req, b_msg, b_cd, b_io, b_sel, b_dbp};
  endfunction

  function automatic logic odd_ok(logic [7:0] d, logic p);
    return ^{d, p};
  endfunction

  initial begin
    int wd_cnt = 0;
    while (!done && wd_cnt < 100000) begin @(posedge clk); wd_cnt++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [2:0] ph, ex;
    void'($urandom(32'd1234));
    {b_rst, b_bsy, b_sel, b_req, b_ack, b_atn, b_msg, b_cd, b_io, b_dbp} = '0;
    b_db = 0; d_req = 0; d_eop = 0; ra = 0; rw = 0; rr = 0; wd = 0;
    rst = 1;
    waitc(3);
    rst = 0;
    waitc(4);
    // R1 reset state
    chk("R1 latch", lat, 8'h08);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rreg(3'd2, v); chk("R1 mode", v, 8'h00);
    rreg(3'd3, v); chk("R1 phase", v, 8'h00);

    // R10 register access
    wreg(3'd2, 8'hFA); rreg(3'd2, v); chk("R10 mode rd", v, 8'h0A);
    wreg(3'd3, 8'hFE); rreg(3'd3, v); chk("R10 phase rd", v, 8'h06);
    rreg(3'd6, v); chk("R10 unused addr", v, 8'h00);
    wreg(3'd2, 8'h00);

    // R2 latency: change at negedge, visible after 3 edges, not after 2
    b_bsy = 1; b_sel = 1;
    waitc(2); chk("R2 not yet", live, 8'h00);
    waitc(1); chk("R2 latency", live, 8'h42);
    rreg(3'd0, v); chk("R10 live read", v, 8'h42);

    // R2 R3 R4 random patterns, mode 0 so no flags
    for (int i = 0; i < 60; i++) begin
      ex = 3'($urandom);
      wreg(3'd3, {5'b0, ex});
      {b_rst, b_bsy, b_req, b_sel, b_ack, b_atn, b_dbp} = 7'($urandom);
      ph = 3'($urandom);
      {b_msg, b_cd, b_io} = ph;
      b_db = 8'($urandom);
      d_req = 1'($urandom);
      d_eop = 1'($urandom);
      waitc(4);
      chk("R2 live", live, exp_live());
      chk("R4 latch", lat, {d_eop, d_req, 1'b0, 1'b0, (ph == ex), 1'b0, b_atn, b_ack});
      chk("R3 match", {7'b0, lat[3]}, {7'b0, ph == ex});
    end
    {b_rst, b_bsy, b_req, b_sel, b_ack, b_atn, b_dbp} = '0;
    d_eop = 0; d_req = 0;
    waitc(4);
    // R3 named phase codes: message-in 111, status 011
    wreg(3'd3, 8'h07); {b_msg, b_cd, b_io} = 3'b111; waitc(4);
    chk("R3 msg-in match", {7'b0, lat[3]}, 8'h01);
    {b_msg, b_cd, b_io} = 3'b011; waitc(4);
    chk("R3 status mismatch", {7'b0, lat[3]}, 8'h00);
    rreg(3'd4, v); waitc(1);

    // R6 R7 random parity with checking and interrupt enabled
    wreg(3'd2, 8'h03);
    for (int i = 0; i < 60; i++) begin
      rreg(3'd4, v);
      b_io = 1'($urandom); b_msg = 0; b_cd = 0;
      b_db = 8'($urandom); b_dbp = 1'($urandom);
      b_req = 0; waitc(4);
      b_req = 1; waitc(4);
      chk("R6 perr", {7'b0, lat[5]}, {7'b0, b_io & ~odd_ok(b_db, b_dbp)});
      chk("R7 irq", {7'b0, irq}, {7'b0, b_io & ~odd_ok(b_db, b_dbp)});
      b_req = 0; waitc(4);
    end
    // R6 parity check disabled: bad byte leaves flag clear
    rreg(3'd4, v); wreg(3'd2, 8'h02);
    b_io = 1; b_db = 8'h01; b_dbp = 1; waitc(4);
    b_req = 1; waitc(4);
    chk("R6 disabled", lat & 8'h30, 8'h00);
    b_req = 0; waitc(4);
    // R7 check on, interrupt off: flag set, irq low
    wreg(3'd2, 8'h01);
    b_req = 1; waitc(4);
    chk("R7 perr only", lat & 8'h30, 8'h20);
    chk("R11 irq low", {7'b0, irq}, 8'h00);
    b_req = 0; waitc(4);
    // R5 clear read returns latched byte then clears
    rreg(3'd4, v);
    chk("R5 clear rd data", v & 8'h20, 8'h20);
    chk("R5 cleared", lat & 8'h34, 8'h00);

    // R8 busy loss without monitor: no effect
    wreg(3'd2, 8'h00);
    b_bsy = 1; waitc(4); b_bsy = 0; waitc(4);
    chk("R8 no monitor", lat & 8'h14, 8'h00);
    // R8 with monitor
    wreg(3'd2, 8'h08);
    b_bsy = 1; waitc(4);
    chk("R8 bsy held", lat & 8'h14, 8'h00);
    b_bsy = 0; waitc(4);
    chk("R8 busy loss", lat & 8'h14, 8'h14);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    rreg(3'd4, v); chk("R5 after clear", lat & 8'h34, 8'h00);

    // R9 eop without enable
    wreg(3'd2, 8'h00);
    d_eop = 1; waitc(3);
    chk("R9 no enable", {7'b0, irq}, 8'h00);
    chk("R4 eop bit", lat & 8'h80, 8'h80);
    d_eop = 0; waitc(3);
    // R9 with enable, timed onto a clear read: set wins (R5)
    wreg(3'd2, 8'h04);
    d_eop = 1;
    @(posedge clk); @(negedge clk);
    ra = 3'd4; rr = 1;
    @(posedge clk); @(negedge clk);
    rr = 0;
    chk("R5 set beats clear", {7'b0, irq}, 8'h01);
    chk("R9 eop irq", lat & 8'h10, 8'h10);
    rreg(3'd4, v); chk("R5 final clear", {7'b0, irq}, 8'h00);
    d_eop = 0; waitc(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule